// File: doc/BRIEF.md
# Power-Management Command Port with SMI Trigger

This block sits behind the legacy power-management command port of a chipset. Firmware or an operating system writes a one-byte command to it. Two command codes move the platform between ACPI mode and legacy mode by setting or clearing the SCI-enable bit of the PM1 control register. Every command write can also request a system-management interrupt. That request is allowed only when a gate bit in a small bank of configuration bytes is set. A second port holds a scratch status byte that software may write and read freely.

The configuration bank covers four bytes starting at configuration offset 0x58. The gate is bit 1 of the byte at 0x5B. A strap input chooses the reset value of that byte. With the strap high, the byte resets to 0x02, which marks system management as already initialised and leaves SMI generation enabled from reset. The SCI-enable bit leaves the block as a level signal, and the interrupt request leaves it as a one-cycle pulse.

Two small state machines hold the block's behaviour:
- SMI sequencer. State `SMI_IDLE` moves to `SMI_FIRE` on a gated command write. `SMI_FIRE` stays in `SMI_FIRE` on another gated command write and otherwise returns to `SMI_IDLE`.
- Mode bit. It goes to the ACPI state on code 0xF1 and to the legacy state on code 0xF0.

Top module: `apm_smi_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the command byte, the status byte and `sci_en`, and `smi_pulse` is 0 after that edge.
- R2: A write of 0xF1 to I/O address 0xB2 sets `sci_en` to 1 from the following clock edge.
- R3: A write of 0xF0 to I/O address 0xB2 clears `sci_en` to 0 from the following clock edge.
- R4: A write of any other value to 0xB2 leaves `sci_en` unchanged.
- R5: When bit 1 of configuration byte 0x5B is 1 at the edge that captures a write to 0xB2, `smi_pulse` is 1 for exactly the next cycle. Back-to-back gated writes give one high cycle per write.
- R6: `smi_pulse` stays 0 after a write to 0xB2 while bit 1 of byte 0x5B is 0, whatever the other bits of that byte hold. It also stays 0 after writes to 0xB3 and after configuration writes.
- R7: With the strap low, reset clears configuration bytes 0x58 to 0x5B to zero. Each of these bytes reads back the last value written. Configuration offsets outside 0x58 to 0x5B read 0, and writes to them change nothing.
- R8: With `smm_strap` high during reset, byte 0x5B resets to 0x02 while 0x58 to 0x5A reset to zero. A command write then produces an SMI pulse.
- R9: `io_rdata` returns, in the same cycle, the last byte written to the addressed port: 0xB2 for the command byte, 0xB3 for the status byte. Any other address returns 0.
- R10: A write to 0xB3 changes neither `sci_en` nor the stored command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smm_strap | input | 1 | Selects 0x02 as the reset value of configuration byte 0x5B |
| io_wr_en | input | 1 | I/O byte write strobe |
| io_addr | input | 16 | I/O address for writes and reads |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Stored byte at `io_addr` (combinational) |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration byte at `cfg_addr` (combinational) |
| sci_en | output | 1 | SCI-enable level, bit 0 of PM1 control |
| smi_pulse | output | 1 | One-cycle system-management interrupt request |

## Verification
`sci_en` and `smi_pulse` are due one clock edge after the cycle that presents a write. Both read buses answer combinationally in the cycle the address is presented. Each expected item in the scoreboard carries the cycle it is due in. The monitor compares only items whose due cycle matches the current cycle, sampling on the falling edge. An idle step after every gated write checks that the pulse has dropped again.

// File: rtl/apm_smi_pkg.sv
package apm_smi_pkg;

    typedef enum logic [0:0] {
        SMI_IDLE = 1'b0,
        SMI_FIRE = 1'b1
    } smi_state_e;

endpackage

// File: rtl/apm_cfg_bank.sv
module apm_cfg_bank #(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE    = 8'h58,
    parameter int              COUNT     = 4,
    parameter int              STRAP_IDX = 3,
    parameter logic [7:0]      STRAP_VAL = 8'h02,
    parameter int              GATE_IDX  = 3,
    parameter int              GATE_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              gate_o
);

    localparam int IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam logic [ADDR_W-1:0] LAST = BASE + ADDR_W'(COUNT - 1);

    logic [7:0]       bytes_q [COUNT];
    logic             hit;
    logic [IDX_W-1:0] idx;

    assign hit = (addr >= BASE) && (addr <= LAST);
    assign idx = IDX_W'(addr - BASE);

    for (genvar i = 0; i < COUNT; i++) begin : g_byte
        logic [7:0] rst_val;
        if (i == STRAP_IDX) begin : g_strap
            assign rst_val = strap ? STRAP_VAL : 8'h00;
        end else begin : g_plain
            assign rst_val = 8'h00;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q[i] <= rst_val;
            end else if (wr_en && hit && (idx == IDX_W'(i))) begin
                bytes_q[i] <= wdata;
            end
        end
    end

    assign rdata  = hit ? bytes_q[idx] : 8'h00;
    assign gate_o = bytes_q[GATE_IDX][GATE_BIT];

    // R7: reset without strap empties the strap-controlled byte and its neighbours
    a_r7_reset_clear: assert property (@(posedge clk)
        (!rst_n && !strap) |=> (bytes_q[STRAP_IDX] == 8'h00 && bytes_q[0] == 8'h00));

    // R8: strap selects the marked reset value
    a_r8_strap_reset: assert property (@(posedge clk)
        (!rst_n && strap) |=> (bytes_q[STRAP_IDX] == STRAP_VAL));

endmodule

// File: rtl/apm_port_regs.sv
module apm_port_regs #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h00B2,
    parameter logic [ADDR_W-1:0] STS_ADDR = 16'h00B3,
    parameter logic [7:0]        ON_CODE  = 8'hF1,
    parameter logic [7:0]        OFF_CODE = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              sci_en,
    output logic              cmd_wr
);

    logic [7:0] cmd_q;
    logic [7:0] sts_q;
    logic       sci_q;
    logic       sts_wr;

    assign cmd_wr = wr_en && (addr == CMD_ADDR);
    assign sts_wr = wr_en && (addr == STS_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= 8'h00;
            sts_q <= 8'h00;
            sci_q <= 1'b0;
        end else begin
            if (cmd_wr) begin
                cmd_q <= wdata;
                if (wdata == ON_CODE) begin
                    sci_q <= 1'b1;
                end else if (wdata == OFF_CODE) begin
                    sci_q <= 1'b0;
                end
            end
            if (sts_wr) begin
                sts_q <= wdata;
            end
        end
    end

    always_comb begin
        if (addr == CMD_ADDR) begin
            rdata = cmd_q;
        end else if (addr == STS_ADDR) begin
            rdata = sts_q;
        end else begin
            rdata = 8'h00;
        end
    end

    assign sci_en = sci_q;

    a_r2_acpi_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CMD_ADDR && wdata == ON_CODE) |=> sci_en);

    a_r3_acpi_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CMD_ADDR && wdata == OFF_CODE) |=> !sci_en);

    a_r4_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CMD_ADDR && wdata != ON_CODE && wdata != OFF_CODE)
        |=> $stable(sci_en));

    a_r10_status_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == STS_ADDR) |=> ($stable(sci_en) && $stable(cmd_q)));

    a_r9_status_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == STS_ADDR) |=> (sts_q == $past(wdata)));

endmodule

// File: rtl/apm_smi_fsm.sv
module apm_smi_fsm
    import apm_smi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic gate,
    output logic smi
);

    smi_state_e state_q;
    smi_state_e state_d;
    logic       fire;

    assign fire = cmd_wr && gate;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SMI_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMI_IDLE: if (fire)  state_d = SMI_FIRE;
            SMI_FIRE: if (!fire) state_d = SMI_IDLE;
            default:             state_d = SMI_IDLE;
        endcase
    end

    always_comb begin
        smi = 1'b0;
        unique case (state_q)
            SMI_IDLE: smi = 1'b0;
            SMI_FIRE: smi = 1'b1;
            default:  smi = 1'b0;
        endcase
    end

    a_r5_fire_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && gate) |=> smi);

    a_r6_quiet_next: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_wr && gate) |=> !smi);

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !smi);

endmodule

// File: rtl/apm_smi_ctrl.sv
module apm_smi_ctrl #(
    parameter int                    IO_ADDR_W    = 16,
    parameter logic [IO_ADDR_W-1:0]  CMD_PORT     = 16'h00B2,
    parameter logic [IO_ADDR_W-1:0]  STS_PORT     = 16'h00B3,
    parameter logic [7:0]            ACPI_ON      = 8'hF1,
    parameter logic [7:0]            ACPI_OFF     = 8'hF0,
    parameter int                    CFG_ADDR_W   = 8,
    parameter logic [CFG_ADDR_W-1:0] CFG_BASE     = 8'h58,
    parameter int                    CFG_COUNT    = 4,
    parameter int                    SMI_CFG_IDX  = 3,
    parameter int                    SMI_GATE_BIT = 1,
    parameter logic [7:0]            SMM_MARK     = 8'h02
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smm_strap,
    input  logic                  io_wr_en,
    input  logic [IO_ADDR_W-1:0]  io_addr,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    input  logic                  cfg_wr_en,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [7:0]            cfg_wdata,
    output logic [7:0]            cfg_rdata,
    output logic                  sci_en,
    output logic                  smi_pulse
);

    logic cmd_wr;
    logic smi_gate;

    apm_port_regs #(
        .ADDR_W   (IO_ADDR_W),
        .CMD_ADDR (CMD_PORT),
        .STS_ADDR (STS_PORT),
        .ON_CODE  (ACPI_ON),
        .OFF_CODE (ACPI_OFF)
    ) u_ports (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (io_wr_en),
        .addr   (io_addr),
        .wdata  (io_wdata),
        .rdata  (io_rdata),
        .sci_en (sci_en),
        .cmd_wr (cmd_wr)
    );

    apm_cfg_bank #(
        .ADDR_W    (CFG_ADDR_W),
        .BASE      (CFG_BASE),
        .COUNT     (CFG_COUNT),
        .STRAP_IDX (SMI_CFG_IDX),
        .STRAP_VAL (SMM_MARK),
        .GATE_IDX  (SMI_CFG_IDX),
        .GATE_BIT  (SMI_GATE_BIT)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .strap  (smm_strap),
        .wr_en  (cfg_wr_en),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .gate_o (smi_gate)
    );

    apm_smi_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_wr (cmd_wr),
        .gate   (smi_gate),
        .smi    (smi_pulse)
    );

endmodule

// File: tb/apm_smi_ctrl_bench.sv
`timescale 1ns/1ps
module apm_smi_ctrl_bench;

    typedef struct {
        int         due;
        bit         c_sci;
        bit         e_sci;
        bit         c_smi;
        bit         e_smi;
        bit         c_io;
        logic [7:0] e_io;
        bit         c_cfg;
        logic [7:0] e_cfg;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smm_strap = 1'b0;
    logic        io_wr_en = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h0;
    logic [7:0]  cfg_wdata = 8'h0;
    logic [7:0]  cfg_rdata;
    logic        sci_en;
    logic        smi_pulse;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];
    exp_t e;

    // model state
    bit         m_sci;
    logic [7:0] m_cmd;
    logic [7:0] m_sts;
    logic [7:0] m_cfg [4];

    always #2.5 clk = ~clk;

    apm_smi_ctrl u_apm_smi_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .smm_strap (smm_strap),
        .io_wr_en  (io_wr_en),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .sci_en    (sci_en),
        .smi_pulse (smi_pulse)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // monitor: compare every item due in the current cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            e = q.pop_front();
            if (e.c_sci) check(sci_en == e.e_sci, e.tag, "sci_en", int'(sci_en), int'(e.e_sci));
            if (e.c_smi) check(smi_pulse == e.e_smi, e.tag, "smi_pulse", int'(smi_pulse), int'(e.e_smi));
            if (e.c_io)  check(io_rdata == e.e_io, e.tag, "io_rdata", int'(io_rdata), int'(e.e_io));
            if (e.c_cfg) check(cfg_rdata == e.e_cfg, e.tag, "cfg_rdata", int'(cfg_rdata), int'(e.e_cfg));
        end
    end

    function automatic bit cfg_hit(logic [7:0] a);
        return (a >= 8'h58) && (a <= 8'h5B);
    endfunction

    function automatic logic [7:0] cfg_model(logic [7:0] a);
        return cfg_hit(a) ? m_cfg[a - 8'h58] : 8'h00;
    endfunction

    function automatic logic [7:0] io_model(logic [15:0] a);
        if (a == 16'h00B2) return m_cmd;
        if (a == 16'h00B3) return m_sts;
        return 8'h00;
    endfunction

    // one driven cycle; optional same-cycle read checks, then post-edge checks
    task automatic step(bit iw, logic [15:0] ia, logic [7:0] id,
                        bit cw, logic [7:0] ca, logic [7:0] cd,
                        bit rd_io, bit rd_cfg, string tag);
        exp_t s;
        exp_t p;
        bit   exp_smi;
        @(posedge clk);
        #1;
        io_wr_en  = iw;  io_addr  = ia; io_wdata  = id;
        cfg_wr_en = cw;  cfg_addr = ca; cfg_wdata = cd;
        if (rd_io || rd_cfg) begin
            s = '{due: cyc, c_sci: 0, e_sci: 0, c_smi: 0, e_smi: 0,
                  c_io: rd_io, e_io: io_model(ia), c_cfg: rd_cfg, e_cfg: cfg_model(ca), tag: tag};
            q.push_back(s);
        end
        exp_smi = iw && (ia == 16'h00B2) && m_cfg[3][1];
        if (iw && ia == 16'h00B2) begin
            m_cmd = id;
            if (id == 8'hF1) m_sci = 1'b1;
            else if (id == 8'hF0) m_sci = 1'b0;
        end
        if (iw && ia == 16'h00B3) m_sts = id;
        if (cw && cfg_hit(ca)) m_cfg[ca - 8'h58] = cd;
        p = '{due: cyc + 1, c_sci: 1, e_sci: m_sci, c_smi: 1, e_smi: exp_smi,
              c_io: 0, e_io: 8'h00, c_cfg: 0, e_cfg: 8'h00, tag: tag};
        q.push_back(p);
    endtask

    task automatic io_write(logic [15:0] a, logic [7:0] d, string tag);
        step(1'b1, a, d, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic cfg_write(logic [7:0] a, logic [7:0] d, string tag);
        step(1'b0, 16'h0000, 8'h00, 1'b1, a, d, 1'b0, 1'b0, tag);
    endtask

    task automatic read_both(logic [15:0] ia, logic [7:0] ca, string tag);
        step(1'b0, ia, 8'h00, 1'b0, ca, 8'h00, 1'b1, 1'b1, tag);
    endtask

    task automatic idle(string tag);
        step(1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic do_reset(bit strap);
        @(posedge clk);
        #1;
        rst_n = 1'b0; smm_strap = strap;
        io_wr_en = 1'b0; cfg_wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_sci = 1'b0; m_cmd = 8'h00; m_sts = 8'h00;
        for (int i = 0; i < 4; i++) m_cfg[i] = 8'h00;
        if (strap) m_cfg[3] = 8'h02;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 / R7: reset state, strap low
        do_reset(1'b0);
        read_both(16'h00B2, 8'h58, "R1");
        read_both(16'h00B3, 8'h5B, "R7");
        read_both(16'h00B2, 8'h5A, "R7");

        // R2 with gate clear: mode set, no SMI (R6)
        io_write(16'h00B2, 8'hF1, "R2");
        read_both(16'h00B2, 8'h59, "R9");
        // R4: other code leaves mode
        io_write(16'h00B2, 8'h55, "R4");
        io_write(16'h00B2, 8'hF2, "R4");
        // R10: status write isolated
        io_write(16'h00B3, 8'hA5, "R10");
        read_both(16'h00B3, 8'h58, "R9");
        read_both(16'h00B2, 8'h58, "R10");
        read_both(16'h0080, 8'h57, "R9");

        // R7: config writes and ignored offsets
        cfg_write(8'h58, 8'h11, "R7");
        cfg_write(8'h59, 8'h22, "R7");
        cfg_write(8'h5A, 8'h33, "R7");
        cfg_write(8'h5C, 8'hFF, "R7");
        cfg_write(8'h57, 8'hFF, "R7");
        read_both(16'h00B2, 8'h58, "R7");
        read_both(16'h00B2, 8'h59, "R7");
        read_both(16'h00B2, 8'h5A, "R7");
        read_both(16'h00B2, 8'h5C, "R7");
        read_both(16'h00B2, 8'h5B, "R7");

        // R6: other gate-byte bits set, gate bit clear
        cfg_write(8'h5B, 8'hFD, "R6");
        io_write(16'h00B2, 8'h12, "R6");
        idle("R6");

        // R5 / R3: gate on, disable code fires SMI
        cfg_write(8'h5B, 8'h02, "R7");
        read_both(16'h00B2, 8'h5B, "R7");
        io_write(16'h00B2, 8'hF0, "R3");
        idle("R5");
        io_write(16'h00B2, 8'hF1, "R5");
        io_write(16'h00B2, 8'h77, "R5");
        idle("R5");
        idle("R5");
        // R6: status write with gate set gives no SMI
        io_write(16'h00B3, 8'h3C, "R6");
        io_write(16'h00B2, 8'hF0, "R3");
        idle("R5");

        // R1: reset mid-run clears ports and mode
        io_write(16'h00B2, 8'hF1, "R2");
        do_reset(1'b0);
        read_both(16'h00B2, 8'h5B, "R1");
        read_both(16'h00B3, 8'h58, "R1");
        io_write(16'h00B2, 8'h44, "R6");

        // R8: strap reset
        cfg_write(8'h58, 8'hEE, "R8");
        do_reset(1'b1);
        read_both(16'h00B2, 8'h5B, "R8");
        read_both(16'h00B2, 8'h58, "R8");
        io_write(16'h00B2, 8'h01, "R8");
        idle("R8");

        idle("R1");
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        check(q.size() == 0, "R1", "scoreboard drained", q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule